// File: doc/BRIEF.md
# Per-Core Interval Tick Timer Bank

A bank of identical local timers, one per processor core, each reached through its own 256-byte address window. Every timer is a two-stage counter: a prescaler that emits one tick every (prescale value + 1) input clocks, followed by an event counter that counts those ticks down and flags an interrupt when it runs out. Software programs the two buffer values, enables the interrupt output and sets the start bits in the control register. From then on the timer raises its interrupt repeatedly until software clears the start bits. A one-shot use therefore depends on software stopping the timer from its handler.

Register writes are posted. Each write to a buffer or to control sets its own acknowledge bit in a write-status register, and software clears that bit by writing 1 to it. The event-count buffer only takes a new value when bit 31 of the write is set. Reads are combinational from the address. The bus is a plain single-cycle register port with no back-pressure, because every access completes in the cycle it is issued. The interrupt lines are level outputs, one per timer.

Top module: `tick_timer_bank`

## Requirements
- R1: Timer n is addressed at BASE_ADDR + 0x100*n, and address bits [7:0] pick the register: prescale buffer 0x00, event buffer 0x08, control 0x20, interrupt status 0x30, interrupt enable 0x34, write status 0x40. An address outside every window, or an unused offset, reads 0.
- R2: While control bit 0 is 1, the prescaler emits one tick every (prescale buffer + 1) clocks. While bit 0 is 0, the prescaler is held at its start.
- R3: While control bit 1 is 1, the event counter counts ticks and expires on the tick that takes it from 1, or from 0, to empty. A run that starts with both start bits written at edge E0 expires, and sets interrupt status bit 0, at edge E0 + (prescale+1)*count.
- R4: With control bit 2 (interval) set, the counter reloads from its buffer on expiry, so expiries repeat every (prescale+1)*count clocks.
- R5: With control bit 2 clear, the counter reloads to 0x7FFFFFFF on expiry, so no further expiry comes within that range.
- R6: A write to the event buffer with bit 31 set stores bits [30:0] and loads them into the counter. With bit 31 clear, the buffer is left unchanged.
- R7: A write to the prescale buffer, the event buffer or control sets write-status bit 0, 1 or 3 respectively, and does so even when the event-buffer write was ignored. Writing 1 to a write-status bit clears it.
- R8: Interrupt status bit 0 is cleared by writing 1 to it. An expiry in the same cycle as that write wins.
- R9: The interrupt output of a timer equals status bit 0 AND interrupt-enable bit 0.
- R10: Clearing control bits 0 and 1 freezes the timer. Setting them again restarts from the full buffered values.
- R11: After reset, every register reads 0 and every interrupt output is low.
- R12: Timers are independent, so activity in one window never changes another timer's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | NUM_TIMERS | Interrupt level per timer |

## Verification
The bench builds the bank with three timers at the default base and 32-bit prescaler. Three windows let one run place every timer, the gap above the last window, and the cross-timer isolation within reach. Prescale values of 0 to 3 and counts of 1 to 6 keep every period under ten clocks. As a result, the exact expiry edge, the second interval expiry, a clear that lands on an expiry edge, and a stop followed by a restart can all be timed to the cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int REG_W = 32;
  localparam int IC_W  = 31;

  localparam logic [7:0] OFF_PRE  = 8'h00;
  localparam logic [7:0] OFF_EVT  = 8'h08;
  localparam logic [7:0] OFF_CTL  = 8'h20;
  localparam logic [7:0] OFF_ISTS = 8'h30;
  localparam logic [7:0] OFF_IEN  = 8'h34;
  localparam logic [7:0] OFF_WSTS = 8'h40;

  // bit 2 interval, bit 1 event counter run, bit 0 prescaler run
  typedef struct packed {
    logic interval;
    logic evt_run;
    logic pre_run;
  } ctl_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = run && (pcnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (!run)   pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

  // R2
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));
endmodule

// File: rtl/tt_evtcnt.sv
module tt_evtcnt #(
  parameter int IC_W = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            interval,
  input  logic            tick,
  input  logic            load,
  input  logic [IC_W-1:0] load_val,
  input  logic [IC_W-1:0] buf_val,
  output logic            expire
);
  logic [IC_W-1:0] icnt;

  assign expire = run && tick && (icnt <= IC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            icnt <= '0;
    else if (load)         icnt <= load_val;
    else if (!run)         icnt <= buf_val;
    else if (expire)       icnt <= interval ? buf_val : '1;
    else if (tick)         icnt <= icnt - 1'b1;
  end

  // R4 R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> (icnt == ($past(interval) ? $past(buf_val) : {IC_W{1'b1}})));

  // R10
  frozen_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> (icnt == $past(buf_val)));
endmodule

// File: rtl/tt_unit.sv
module tt_unit
  import tt_pkg::*;
#(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       off,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq_o
);
  logic [PRE_W-1:0] pre_buf;
  logic [IC_W-1:0]  evt_buf;
  ctl_t             ctl;
  logic             ists, ien;
  logic [3:0]       wsts;
  logic             tick, expire;

  logic wr_pre, wr_evt, wr_ctl, wr_ists, wr_ien, wr_wsts, evt_upd;
  assign wr_pre  = wr_en && (off == OFF_PRE);
  assign wr_evt  = wr_en && (off == OFF_EVT);
  assign wr_ctl  = wr_en && (off == OFF_CTL);
  assign wr_ists = wr_en && (off == OFF_ISTS);
  assign wr_ien  = wr_en && (off == OFF_IEN);
  assign wr_wsts = wr_en && (off == OFF_WSTS);
  assign evt_upd = wr_evt && wdata[REG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_buf <= '0;
      evt_buf <= '0;
      ctl     <= '0;
      ien     <= 1'b0;
    end else begin
      if (wr_pre)  pre_buf <= wdata[PRE_W-1:0];
      if (evt_upd) evt_buf <= wdata[IC_W-1:0];
      if (wr_ctl)  ctl     <= ctl_t'(wdata[2:0]);
      if (wr_ien)  ien     <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsts <= '0;
      ists <= 1'b0;
    end else begin
      wsts[0] <= wr_pre | (wsts[0] & ~(wr_wsts & wdata[0]));
      wsts[1] <= wr_evt | (wsts[1] & ~(wr_wsts & wdata[1]));
      wsts[2] <= 1'b0;
      wsts[3] <= wr_ctl | (wsts[3] & ~(wr_wsts & wdata[3]));
      ists    <= expire | (ists & ~(wr_ists & wdata[0]));
    end
  end

  tt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl.pre_run), .div(pre_buf), .tick(tick)
  );

  tt_evtcnt #(.IC_W(IC_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .run(ctl.evt_run), .interval(ctl.interval),
    .tick(tick), .load(evt_upd), .load_val(wdata[IC_W-1:0]),
    .buf_val(evt_buf), .expire(expire)
  );

  assign irq_o = ists & ien;

  always_comb begin
    rdata = '0;
    case (off)
      OFF_PRE:  rdata[PRE_W-1:0] = pre_buf;
      OFF_EVT:  rdata[IC_W-1:0]  = evt_buf;
      OFF_CTL:  rdata[2:0]       = ctl;
      OFF_ISTS: rdata[0]         = ists;
      OFF_IEN:  rdata[0]         = ien;
      OFF_WSTS: rdata[3:0]       = wsts;
      default:  rdata            = '0;
    endcase
  end

  // R8
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ists);

  // R7
  ctl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> wsts[3]);

  // R6
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !wdata[REG_W-1]) |=> $stable(evt_buf));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tt_pkg::*;
#(
  parameter int              NUM_TIMERS = 2,
  parameter int              ADDR_W     = 16,
  parameter logic [15:0]     BASE_ADDR  = 16'h0300,
  parameter int              PRE_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int WIN_W = ADDR_W - 8;
  localparam logic [WIN_W-1:0] WIN_BASE = WIN_W'(BASE_ADDR >> 8);

  logic [NUM_TIMERS-1:0] sel;
  logic [REG_W-1:0]      unit_rd [NUM_TIMERS];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    assign sel[g] = (addr[ADDR_W-1:8] == WIN_BASE + WIN_W'(g));

    tt_unit #(.PRE_W(PRE_W)) u_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && sel[g]),
      .off(addr[7:0]), .wdata(wdata), .rdata(unit_rd[g]), .irq_o(irq[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_TIMERS; k++)
      if (sel[k]) rdata = unit_rd[k];
  end

  // R1
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb;
  localparam int NT = 3;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NT-1:0] irq;
  int cyc = 0, nchk = 0, nerr = 0;

  tick_timer_bank #(.NUM_TIMERS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // rows: timer, prescale, count
  localparam int VT [4][3] = '{'{0, 1, 3}, '{1, 0, 5}, '{2, 3, 2}, '{0, 2, 1}};

  function automatic logic [15:0] ra(int t, logic [7:0] o);
    return 16'h0300 + 16'(t * 256) + 16'(o);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_to(int target);
    while (cyc < target) begin @(posedge clk); #1; end
  endtask

  task automatic arm(int t, int pre, int cnt, logic [2:0] mode, logic en, output int c0);
    wr(ra(t, 8'h20), 0);
    wr(ra(t, 8'h30), 1);
    wr(ra(t, 8'h00), 32'(pre));
    wr(ra(t, 8'h08), 32'h8000_0000 | 32'(cnt));
    wr(ra(t, 8'h34), {31'b0, en});
    wr(ra(t, 8'h20), {29'b0, mode});
    c0 = cyc;
  endtask

  initial begin
    #(200000 * 10);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0, p;
    #12 rst_n = 1;
    @(posedge clk); #1;

    // R11 reset state
    rd(ra(0, 8'h20), v); check("R11 ctl", v, 0);
    rd(ra(0, 8'h08), v); check("R11 evt", v, 0);
    rd(ra(1, 8'h40), v); check("R11 wsts", v, 0);
    check("R11 irq", {29'b0, irq}, 0);

    // R2 R3 R4 table walk
    for (int i = 0; i < 4; i++) begin
      int t;
      t = VT[i][0];
      p = (VT[i][1] + 1) * VT[i][2];
      arm(t, VT[i][1], VT[i][2], 3'b111, 1'b1, c0);
      wait_to(c0 + p - 1);
      rd(ra(t, 8'h30), v); check("R2 R3 before expiry", v, 0);
      wait_to(c0 + p);
      rd(ra(t, 8'h30), v); check("R3 expiry", v, 1);
      check("R9 irq", {31'b0, irq[t]}, 1);
      wr(ra(t, 8'h30), 1);
      wait_to(c0 + 2 * p - 1);
      rd(ra(t, 8'h30), v); check("R4 before second", v, 0);
      wait_to(c0 + 2 * p);
      rd(ra(t, 8'h30), v); check("R4 second expiry", v, 1);
      wr(ra(t, 8'h20), 0);
      wr(ra(t, 8'h30), 1);
    end

    // R1 address map
    rd(ra(2, 8'h00), v); check("R1 t2 prescale", v, 3);
    rd(ra(3, 8'h00), v); check("R1 beyond bank", v, 0);
    rd(16'h0220, v);     check("R1 below base", v, 0);
    rd(ra(0, 8'h10), v); check("R1 unused offset", v, 0);

    // R7 write status
    rd(ra(0, 8'h40), v); check("R7 acks set", v, 32'hB);
    wr(ra(0, 8'h40), 1);
    rd(ra(0, 8'h40), v); check("R7 clear bit0", v, 32'hA);
    wr(ra(0, 8'h40), 32'hA);
    rd(ra(0, 8'h40), v); check("R7 clear all", v, 0);

    // R6 event buffer write without update flag
    wr(ra(0, 8'h08), 32'h0000_0009);
    rd(ra(0, 8'h08), v); check("R6 ignored", v, 1);
    rd(ra(0, 8'h40), v); check("R7 ack on ignored", v, 32'h2);

    // R5 one-shot range, R8 set wins, R12 isolation
    arm(1, 0, 4, 3'b011, 1'b1, c0);
    wait_to(c0 + 3);
    wr(ra(1, 8'h30), 1);
    rd(ra(1, 8'h30), v); check("R8 set wins", v, 1);
    wr(ra(1, 8'h30), 1);
    wait_to(c0 + 30);
    rd(ra(1, 8'h30), v); check("R5 no repeat", v, 0);
    check("R12 timer0 quiet", {31'b0, irq[0]}, 0);
    rd(ra(0, 8'h20), v); check("R12 timer0 ctl", v, 0);
    wr(ra(1, 8'h20), 0);

    // R9 enable gating
    arm(2, 0, 2, 3'b111, 1'b0, c0);
    wait_to(c0 + 2);
    rd(ra(2, 8'h30), v); check("R9 status set", v, 1);
    check("R9 masked irq", {31'b0, irq[2]}, 0);
    wr(ra(2, 8'h20), 0);

    // R10 freeze and restart
    arm(0, 0, 6, 3'b111, 1'b1, c0);
    wait_to(c0 + 3);
    wr(ra(0, 8'h20), 32'h4);
    wait_to(c0 + 25);
    rd(ra(0, 8'h30), v); check("R10 frozen", v, 0);
    wr(ra(0, 8'h20), 32'h7);
    c0 = cyc;
    wait_to(c0 + 5);
    rd(ra(0, 8'h30), v); check("R10 restart early", v, 0);
    wait_to(c0 + 6);
    rd(ra(0, 8'h30), v); check("R10 restart full", v, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule